// File: doc/BRIEF.md
# Satellite Ranging Code Generator With Phase Slew

This block produces the 1023-chip Gold code that one receiver channel correlates against. The code comes from two 10-stage linear feedback shift registers. The first register always starts from all ones. The second starts from a preset word, and that word selects the satellite code. The block advances one chip for every two pulses of a half-chip enable. It passes the code through a short delay line clocked at the half-chip rate. The middle tap of that line is the prompt arm. The tracking arm is taken half a chip ahead of prompt or half a chip behind it.

While the channel reset is held low, the block loads the preset and a slew count. After release, the generator stays frozen for the programmed number of chip periods and then runs freely. The code phase is therefore shifted by a chosen amount, so a search can step through every phase of the fixed-length code. Each time the first register comes back to all ones, the block emits a one-cycle epoch pulse. That pulse is also the accumulator dump strobe, and it sets a sticky new-data flag that the processor clears.

Top module: `ca_code_gen`

## Requirements
- R1: While `chan_rst_n` is low, `prompt`, `track`, `epoch` and `new_data` read 0 one clock after the edge, and the first register is held at all ones.
- R2: After release with no slew, `prompt` follows the sequence of stage 10 of the first register XOR stage 10 of the second register. The first register feeds back stages 3 and 10. The second register feeds back stages 2, 3, 6, 8, 9 and 10. Both registers shift from stage 1 toward stage 10. The second register starts from `g2_init`, where bit 0 is stage 1 and bit 9 is stage 10. Counting edges where `hc_en` is high since release, with n such edges, `prompt` equals code chip number floor((n-2)/2), and 0 for n<2.
- R3: The generator advances one chip on every second clock edge where `hc_en` is high, and the first advance comes on the second such edge after release. Edges with `hc_en` low change no output except `epoch` and `new_data`.
- R4: `trk_late`=0 makes `track` lead `prompt` by one half-chip enable. `trk_late`=1 makes it lag `prompt` by one half-chip enable. The select acts combinationally on the output.
- R5: With slew value S loaded during channel reset, the first S chip periods after release leave the code frozen. The whole sequence is delayed by S chips.
- R6: `epoch` is high for exactly one clock after each chip advance that returns the first register to all ones. This happens once every 1023 chips.
- R7: `new_data` is set together with `epoch`. It stays set until a clock edge with `clr_new` high and no epoch, because a set wins over a clear. Channel reset clears it.
- R8: `g2_init` and `slew` are sampled only while `chan_rst_n` is low. Changing them while the channel runs has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hc_en | input | 1 | Half-chip enable, twice the chip rate |
| chan_rst_n | input | 1 | Channel reset, active low; its release starts the code |
| g2_init | input | 10 | Second register preset that selects the code |
| slew | input | SLEW_W | Chip periods to hold after release |
| trk_late | input | 1 | Tracking arm select: 0 early, 1 late |
| clr_new | input | 1 | Clear pulse for the new-data flag |
| prompt | output | 1 | Prompt code chip |
| track | output | 1 | Tracking arm code chip |
| epoch | output | 1 | Code wrap pulse, also the dump strobe |
| new_data | output | 1 | Sticky accumulation-ready flag |

## Verification
The bench builds its own Gold table for each random preset and predicts every output from the count of half-chip enables since release. This exposes a generator that advances on both phases, one whose delay line is off by a tap, or one with the early and late arms swapped. Slew values of 0, small random values and 1022 are covered. A wrong hold count shifts the epoch position, and a generator that ignores the hold shows the undelayed code. Clear pulses arrive at random, including on the epoch edge itself, so a flag where the clear wins would drop back to 0. The preset and slew inputs are changed at random during every run, so a design that samples them outside channel reset loses the expected sequence.

// File: rtl/ca_code_gen.sv
module ca_code_gen #(
  parameter int SLEW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_en,
  input  logic              chan_rst_n,
  input  logic [9:0]        g2_init,
  input  logic [SLEW_W-1:0] slew,
  input  logic              trk_late,
  input  logic              clr_new,
  output logic              prompt,
  output logic              track,
  output logic              epoch,
  output logic              new_data
);
  localparam logic [9:0] ONES = '1;

  logic [9:0] g1, g2;
  logic [9:0] g1_nx, g2_nx;
  logic [SLEW_W-1:0] slew_cnt;
  logic ph, e0, e1, e2;

  wire code = g1[9] ^ g2[9];
  wire tick = hc_en & ph;
  wire hold = slew_cnt != '0;
  wire adv  = tick & ~hold;
  wire wrap = adv && (g1_nx == ONES);

  assign g1_nx = {g1[8:0], g1[2] ^ g1[9]};
  assign g2_nx = {g2[8:0], g2[1] ^ g2[2] ^ g2[5] ^ g2[7] ^ g2[8] ^ g2[9]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= ONES; g2 <= ONES; ph <= 1'b0; slew_cnt <= '0;
      e0 <= 1'b0; e1 <= 1'b0; e2 <= 1'b0; epoch <= 1'b0; new_data <= 1'b0;
    end else if (!chan_rst_n) begin
      g1 <= ONES; g2 <= g2_init; ph <= 1'b0; slew_cnt <= slew;
      e0 <= 1'b0; e1 <= 1'b0; e2 <= 1'b0; epoch <= 1'b0; new_data <= 1'b0;
    end else begin
      epoch <= wrap;
      if (wrap) new_data <= 1'b1;
      else if (clr_new) new_data <= 1'b0;
      if (hc_en) begin
        ph <= ~ph;
        e0 <= code; e1 <= e0; e2 <= e1;
      end
      if (tick) begin
        if (hold) slew_cnt <= slew_cnt - 1'b1;
        else begin
          g1 <= g1_nx;
          g2 <= g2_nx;
        end
      end
    end
  end

  assign prompt = e1;
  assign track  = trk_late ? e2 : e0;

  // R1
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_rst_n |=> (g1 == ONES && !epoch && !new_data && !prompt && !track));
  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst_n && !hc_en) |=> ($stable(g1) && $stable(e1) && $stable(e2)));
  // R4
  delay_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst_n && hc_en) |=> (e1 == $past(e0) && e2 == $past(e1)));
  // R5
  slew_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst_n && hold) |=> ($stable(g1) && $stable(g2)));
  // R6
  epoch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |-> (g1 == ONES));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |-> new_data);
endmodule

// File: tb/sim_ca_code_gen.sv
module sim_ca_code_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;

  logic clk = 0, rst_n = 0, hc_en = 0, chan_rst_n = 0, trk_late = 0, clr_new = 0;
  logic [9:0] g2_init = 10'h3FF;
  logic [SW-1:0] slew = '0;
  logic prompt, track, epoch, new_data;

  int vectors = 0, fails = 0;
  logic gold [1023];
  int s_cur, n;
  logic nd, ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  ca_code_gen #(.SLEW_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .hc_en(hc_en), .chan_rst_n(chan_rst_n),
    .g2_init(g2_init), .slew(slew), .trk_late(trk_late), .clr_new(clr_new),
    .prompt(prompt), .track(track), .epoch(epoch), .new_data(new_data));

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask

  task automatic build_gold(logic [9:0] init);
    logic [9:0] a = 10'h3FF, b = init;
    for (int i = 0; i < 1023; i++) begin
      gold[i] = a[9] ^ b[9];
      a = {a[8:0], a[2] ^ a[9]};
      b = {b[8:0], b[1] ^ b[2] ^ b[5] ^ b[7] ^ b[8] ^ b[9]};
    end
  endtask

  function automatic logic code_at(int m);
    int a;
    if (m < 0) return 1'b0;
    a = m / 2 - s_cur;
    if (a < 0) a = 0;
    return gold[a % 1023];
  endfunction

  task automatic run_case(logic [9:0] init, int s, logic late, int hc_pct, int clr_pct, int cycles);
    build_gold(init);
    s_cur = s; n = 0; nd = 0;
    @(negedge clk);
    chan_rst_n = 0; g2_init = init; slew = SW'(s); trk_late = late; hc_en = 1; clr_new = 0;
    repeat (3) @(negedge clk);
    // R1: channel held in reset
    chk("R1 prompt", prompt, 1'b0); chk("R1 track", track, 1'b0);
    chk("R1 epoch", epoch, 1'b0);   chk("R1 new_data", new_data, 1'b0);
    chan_rst_n = 1;
    for (int k = 0; k < cycles; k++) begin
      hc_en = ($urandom % 100) < hc_pct;
      clr_new = ($urandom % 100) < clr_pct;
      // R8: live changes to sampled inputs must be ignored
      g2_init = 10'($urandom); slew = SW'($urandom);
      @(posedge clk);
      ev = 0;
      if (hc_en) begin
        n++;
        if (n % 2 == 0 && n / 2 > s && ((n / 2 - s) % 1023) == 0) ev = 1;
      end
      if (ev) nd = 1; else if (clr_new) nd = 0;
      @(negedge clk);
      // R2 R3 R5 R8 prompt stream
      chk("R2/R5 prompt", prompt, code_at(n - 2));
      // R4 tracking arm
      chk("R4 track", track, late ? code_at(n - 3) : code_at(n - 1));
      // R6 epoch
      chk("R6 epoch", epoch, ev);
      // R7 new_data
      chk("R7 new_data", new_data, nd);
    end
    hc_en = 0; clr_new = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    run_case(10'h3FF, 0, 1'b0, 100, 0, 2200);
    run_case(10'h2A5, 0, 1'b1, 100, 2, 2200);
    run_case(10'h1C3, 5, 1'b0, 60, 1, 4500);
    run_case(10'h0F0, 1022, 1'b1, 100, 0, 4200);
    run_case(10'($urandom | 1), 3 + $urandom % 40, 1'b1, 75, 3, 3200);
    // R3: hc_en never asserted keeps outputs at rest
    run_case(10'h155, 0, 1'b0, 0, 5, 40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule